// File: doc/BRIEF.md
# PLL Control and Status Register

This block is one 8-bit register on a simple CPU bus. It belongs to a clock generator's phase-locked loop. It holds four fields:

- an interrupt enable;
- a lock-change flag, which clears when the register is read;
- a PLL power switch;
- a base clock selector.

The block watches the lock indication of the PLL through a synchronizer. It latches every change of that signal into the flag. It raises an interrupt request when the flag and the enable are both set.

A separate input reports whether automatic bandwidth mode is active. While that mode is off, the enable and the flag are held cleared and read as zero, and writes to the enable are dropped. An interrupt therefore cannot appear from manual mode, and no stale event survives the switch back to automatic mode.

The register decodes a single address, set by a parameter. Read data is combinational from the current state. Writes take effect on the clock edge.

Top module: `pllcr_top`

## Requirements
- R1: After reset a read of the register returns 0x2F. The fields are: enable (bit 7) = 0, flag (bit 6) = 0, PLL on (bit 5) = 1, base clock select (bit 4) = 0, and bits 3..0 = 1.
- R2: Bits 3..0 always read as 1, and writes to them have no effect.
- R3: A write at the configured address updates PLL on (bit 5) and base clock select (bit 4) at the clock edge. A write at any other address changes nothing. A read at any other address returns 0x00.
- R4: A level change of the lock input in either direction sets the flag. The flag becomes visible on the third rising clock edge after the change, counting two synchronizer stages and one edge-detect stage.
- R5: A read at the register address clears the flag at that clock edge. The data returned by the read shows the flag's value from before the read.
- R6: If a lock change is detected in the same cycle as a clearing read, the flag ends up set.
- R7: The interrupt request output is 1 exactly when the flag and the enable (bit 7) are both 1.
- R8: While the automatic-mode input is 0:
  - writes to the enable are ignored;
  - the enable and the flag read as 0;
  - the interrupt request is 0;
  - both stored bits are held cleared, so no stale flag or enable reappears when the mode returns to 1.
- R9: The flag is read-only. A write to bit 6, with either value, neither sets it nor clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational; 0 when no read hits the register |
| pll_lock | input | 1 | Lock indication from the PLL, asynchronous |
| auto_bw | input | 1 | Automatic bandwidth mode active |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a detected lock change that lands in exactly the clock cycle of a clearing read. The detection comes three edges after the pin moves, so the bench flips the lock input and counts two edges. It then holds the read strobe across the third edge, and checks that the returned data shows the flag clear while the interrupt is asserted afterwards. A second hard case is a lock change while automatic mode is off. The bench lets the synchronizer settle fully before it re-enables the mode, then checks that no flag or interrupt has survived.

// File: rtl/pllcr_pkg.sv
package pllcr_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_IE   = 7;
  localparam int BIT_FLAG = 6;
  localparam int BIT_ON   = 5;
  localparam int BIT_BCS  = 4;

  // reset image of the plain field storage (on=1, bcs=0, low nibble ones)
  localparam logic [REG_W-1:0] FIELD_RST  = 8'h2F;
  // bits a CPU write may change in the plain field storage
  localparam logic [REG_W-1:0] FIELD_WMSK = 8'h30;
  // bits of the plain field storage that appear on the read bus
  localparam logic [REG_W-1:0] FIELD_RMSK = 8'h3F;

  // next flag value: event wins over a clearing read, manual mode forces zero
  function automatic logic flag_next(input logic cur, input logic toggle,
                                     input logic clr, input logic auto_on);
    logic keep;
    keep = cur & ~clr;
    return auto_on & (toggle | keep);
  endfunction

  // per-bit masked write
  function automatic logic [REG_W-1:0] masked_wr(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] d,
                                                 input logic [REG_W-1:0] msk);
    return (cur & ~msk) | (d & msk);
  endfunction

  // read image composition
  function automatic logic [REG_W-1:0] read_image(input logic ie, input logic flg,
                                                  input logic auto_on,
                                                  input logic [REG_W-1:0] fields);
    logic [REG_W-1:0] img;
    img = fields & FIELD_RMSK;
    img[BIT_IE]   = ie & auto_on;
    img[BIT_FLAG] = flg & auto_on;
    return img;
  endfunction
endpackage

// File: rtl/pllcr_lock_sync.sv
module pllcr_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic toggle
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign sync_out = chain_q[STAGES-1];
  assign toggle   = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pllcr_event_flag.sv
module pllcr_event_flag
  import pllcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  input  logic clr,
  input  logic auto_on,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, toggle, clr, auto_on);
  end
endmodule

// File: rtl/pllcr_field_reg.sv
module pllcr_field_reg #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    RST  = '0,
  parameter logic [W-1:0]    WMSK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (WMSK[i]) begin : g_rw
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  q[i] <= RST[i];
          else if (wr) q[i] <= d[i];
        end
      end else begin : g_ro
        assign q[i] = RST[i];
      end
    end
  endgenerate
endmodule

// File: rtl/pllcr_top.sv
module pllcr_top
  import pllcr_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C,
  parameter int               SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              pll_lock,
  input  logic              auto_bw,
  output logic              irq
);
  logic             addr_hit;
  logic             rd_hit;
  logic             wr_hit;
  logic             lock_sync;
  logic             lock_toggle;
  logic             flag_q;
  logic             ie_q;
  logic [REG_W-1:0] field_q;
  logic [REG_W-1:0] field_d;

  assign addr_hit = (bus_addr == REG_ADDR);
  assign rd_hit   = addr_hit & bus_rd;
  assign wr_hit   = addr_hit & bus_wr;

  pllcr_lock_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pll_lock),
    .sync_out (lock_sync),
    .toggle   (lock_toggle)
  );

  pllcr_event_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .toggle  (lock_toggle),
    .clr     (rd_hit),
    .auto_on (auto_bw),
    .flag_q  (flag_q)
  );

  // enable: writable only in automatic mode, held cleared otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ie_q <= 1'b0;
    else if (!auto_bw) ie_q <= 1'b0;
    else if (wr_hit)  ie_q <= bus_wdata[BIT_IE];
  end

  assign field_d = masked_wr(field_q, bus_wdata, FIELD_WMSK);

  pllcr_field_reg #(
    .W    (REG_W),
    .RST  (FIELD_RST),
    .WMSK (FIELD_WMSK)
  ) u_fields (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_hit),
    .d     (field_d),
    .q     (field_q)
  );

  assign bus_rdata = rd_hit ? read_image(ie_q, flag_q, auto_bw, field_q) : '0;
  assign irq       = flag_q & ie_q & auto_bw;

  logic unused_sync;
  assign unused_sync = lock_sync;
endmodule

// File: rtl/pllcr_top_chk.sv
module pllcr_top_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_bw,
  input logic rd_hit,
  input logic wr_hit,
  input logic lock_toggle,
  input logic flag_q,
  input logic ie_q
);
  // R4
  lock_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_toggle && auto_bw) |=> flag_q);

  // R5
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !lock_toggle) |=> !flag_q);

  // R8
  manual_mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_bw |=> (!flag_q && !ie_q));

  // R9
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(lock_toggle));

  // R9
  write_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !lock_toggle && !flag_q) |=> !flag_q);
endmodule

bind pllcr_top pllcr_top_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .auto_bw     (auto_bw),
  .rd_hit      (rd_hit),
  .wr_hit      (wr_hit),
  .lock_toggle (lock_toggle),
  .flag_q      (flag_q),
  .ie_q        (ie_q)
);

// File: tb/sim_pllcr_top.sv
`timescale 1ns/1ps
module sim_pllcr_top;
  localparam logic [7:0] RA = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pll_lock = 1'b0;
  logic       auto_bw = 1'b1;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pllcr_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_lock(pll_lock), .auto_bw(auto_bw), .irq(irq)
  );

  // op: 0 write, 1 read and compare
  typedef struct packed {
    logic [1:0] op;
    logic       auto_on;
    logic [7:0] addr;
    logic [7:0] wd;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 1'b1, 8'h3C, 8'h00, 8'h2F},  // R1 reset image
    '{2'd0, 1'b1, 8'h3C, 8'hFF, 8'h00},  // write all ones
    '{2'd1, 1'b1, 8'h3C, 8'h00, 8'hBF},  // R9 flag not set by write, R2 low ones
    '{2'd0, 1'b1, 8'h3C, 8'h00, 8'h00},  // write zeros
    '{2'd1, 1'b1, 8'h3C, 8'h00, 8'h0F},  // R2 R3
    '{2'd0, 1'b1, 8'h3D, 8'hF0, 8'h00},  // write elsewhere
    '{2'd1, 1'b1, 8'h3C, 8'h00, 8'h0F},  // R3 other address ignored
    '{2'd1, 1'b1, 8'h3D, 8'h00, 8'h00},  // R3 read elsewhere returns 0
    '{2'd0, 1'b1, 8'h3C, 8'h10, 8'h00},  // base clock select only
    '{2'd1, 1'b1, 8'h3C, 8'h00, 8'h1F},  // R3
    '{2'd0, 1'b0, 8'h3C, 8'h80, 8'h00},  // enable write in manual mode
    '{2'd1, 1'b0, 8'h3C, 8'h00, 8'h0F},  // R8 ignored
    '{2'd1, 1'b1, 8'h3C, 8'h00, 8'h0F}   // R8 still clear after mode returns
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic flip_and_settle();
    @(negedge clk);
    pll_lock = ~pll_lock;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      auto_bw = VEC[i].auto_on;
      if (VEC[i].op == 2'd0) do_write(VEC[i].addr, VEC[i].wd);
      else begin
        do_read(VEC[i].addr, v);
        chk($sformatf("R1/R2/R3/R8/R9 vector %0d", i), v, VEC[i].exp);
      end
    end

    // R4 R7: rising lock change with enable set
    do_write(RA, 8'h80);
    @(negedge clk);
    pll_lock = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 flag not yet visible after two edges", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R4 R7 irq after rising lock", {7'b0, irq}, 8'h01);
    do_read(RA, v);
    chk("R5 read shows flag before clear", v, 8'hCF);
    chk("R5 irq gone after read", {7'b0, irq}, 8'h00);
    do_read(RA, v);
    chk("R5 flag cleared", v, 8'h8F);

    // R4: falling lock change
    flip_and_settle();
    chk("R4 irq after falling lock", {7'b0, irq}, 8'h01);

    // R9: write with bit6=0 does not clear flag
    do_write(RA, 8'h80);
    chk("R9 write bit6 does not clear", {7'b0, irq}, 8'h01);
    do_read(RA, v);
    chk("R5 clear before collision", v, 8'hCF);

    // R6: detection coincides with clearing read
    @(negedge clk);
    pll_lock = ~pll_lock;
    repeat (2) @(negedge clk);
    bus_addr = RA; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R6 read data shows pre-cycle flag", v, 8'h8F);
    chk("R6 flag survives collision", {7'b0, irq}, 8'h01);
    do_read(RA, v);

    // R8: manual mode masks and holds cleared, no stale event
    flip_and_settle();
    chk("R7 irq set before manual mode", {7'b0, irq}, 8'h01);
    @(negedge clk);
    auto_bw = 1'b0;
    #1 chk("R8 irq masked in manual mode", {7'b0, irq}, 8'h00);
    flip_and_settle();
    repeat (2) @(negedge clk);
    do_read(RA, v);
    chk("R8 manual-mode read", v, 8'h0F);
    @(negedge clk);
    auto_bw = 1'b1;
    @(negedge clk);
    chk("R8 no stale irq", {7'b0, irq}, 8'h00);
    do_read(RA, v);
    chk("R8 no stale enable or flag", v, 8'h0F);

    // R7: flag without enable gives no irq
    flip_and_settle();
    chk("R7 flag without enable", {7'b0, irq}, 8'h00);
    do_read(RA, v);
    chk("R7 flag present", v, 8'h4F);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule